// File: doc/BRIEF.md
# Expansion-Card Bus Wait-State Controller

This block sits on an add-on card attached to a 68000-style asynchronous bus. On that bus a shared motherboard chip normally produces the data-transfer acknowledge for every bus cycle. The block watches the address strobe and the address. When a cycle falls inside the card's own address window, it slows the cycle down until the card is ready. It can do this in one of two ways, chosen by a mode input.

In stall mode the block holds a ready line low. The motherboard holds back its acknowledge until the card lets that line go. In override mode the block asserts an override line, which takes the acknowledge away from the motherboard, and drives the acknowledge itself. In both modes the card is released or acknowledged once a parameterised number of wait clocks has passed and the card's busy input is low.

The early decode path to the ready and override lines is purely combinational from address strobe and address, because those lines must react within a few tens of nanoseconds. Cycles aimed at any other device leave every output inactive.

Top module: `exp_wait_ctrl`

## Requirements
- R1: `dev_sel` is high, combinationally, exactly when `rst_n` is high, `as_n` is low and `(addr & WIN_MASK) == WIN_BASE`; otherwise it is low.
- R2: In stall mode (`mode_ovr`=0), an own-window access drives `xrdy` low combinationally, with no clock edge needed, and `ovr_n` and `dtack_n` stay high for the whole access.
- R3: In stall mode with `busy` low, `xrdy` goes high after the (WAIT_CLKS+1)-th rising clock edge counted from the first edge that sees the access, and stays high until `as_n` rises.
- R4: In override mode (`mode_ovr`=1), an own-window access drives `ovr_n` low combinationally, and `xrdy` stays high for the whole access.
- R5: In override mode with `busy` low, `dtack_n` goes low after the (WAIT_CLKS+1)-th rising edge of the access, and stays low until `as_n` rises.
- R6: While `busy` is high, the release or acknowledge is held back. It happens at the first rising edge at which `busy` is low and at least WAIT_CLKS edges of the access have already passed.
- R7: For an address outside the window, `xrdy` stays high, `ovr_n` and `dtack_n` stay high, and `dev_sel` stays low, in both modes.
- R8: When `as_n` goes high, `xrdy` returns high and `ovr_n`, `dtack_n` return high before the next clock edge. The next access counts its wait clocks from zero.
- R9: `dtack_n` is low only while `ovr_n` is low.
- R10: While `rst_n` is low, all outputs are inactive (`xrdy`, `ovr_n`, `dtack_n` high, `dev_sel` low). An access still in progress when reset is released counts its wait clocks afresh from the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock (about 7 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Bus address |
| as_n | input | 1 | Address strobe, active low |
| busy | input | 1 | Card not yet ready to finish the cycle |
| mode_ovr | input | 1 | 0 = stall through ready line, 1 = override and self-acknowledge |
| xrdy | output | 1 | Ready line to the motherboard; low stalls its acknowledge |
| ovr_n | output | 1 | Override line, active low |
| dtack_n | output | 1 | Card-driven data-transfer acknowledge, active low |
| dev_sel | output | 1 | Local device select for the card's logic |

## Verification
The bench builds the block with WAIT_CLKS=2, a 24-bit address, and a window of base 0xE80000 with mask 0xFF0000. The small wait count keeps each access short. It still lets the bench tell apart an acknowledge set by the counter alone from one held back by `busy` on either side of the count. The window sits with addresses just below and just above its edges, so both boundaries of the decode are exercised alongside far-away foreign addresses.

// File: rtl/exp_wait_pkg.sv
// Package: shared types for the expansion-card wait-state controller.
// Assumes nothing beyond IEEE 1800-2017.
package exp_wait_pkg;

    // How the card delays a bus cycle in its own window.
    typedef enum logic {
        MODE_STALL    = 1'b0,   // hold ready low, motherboard acknowledges
        MODE_OVERRIDE = 1'b1    // take over the acknowledge and drive it here
    } ack_mode_e;

endpackage

// File: rtl/exp_addr_window.sv
// Module: exp_addr_window
// Decodes the card's own address window while the address strobe is low.
// Purely combinational so the early control lines meet their tight budget.
// Assumes the window is given as a base and a mask of equal width.
module exp_addr_window #(
    parameter int ADDR_W = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE = 24'hE80000,
    parameter logic [ADDR_W-1:0] WIN_MASK = 24'hFF0000
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_n,
    output logic              hit
);

    // Window match qualified by strobe and enable.
    always_comb begin
        hit = en && !as_n && ((addr & WIN_MASK) == WIN_BASE);
    end

endmodule

// File: rtl/exp_wait_timer.sv
// Module: exp_wait_timer
// Counts wait clocks for the access in progress and raises a sticky
// ready flag once the count has expired and the card is no longer busy.
// Assumes 'active' stays high for the whole access; dropping it clears all.
module exp_wait_timer #(
    parameter int WAIT_CLKS = 2,
    localparam int CW = $clog2(WAIT_CLKS + 1) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic busy,
    output logic ack
);

    localparam logic [CW-1:0] LIMIT = CW'(WAIT_CLKS);

    logic [CW-1:0] cnt;
    logic          done;

    // Count expired flag.
    always_comb begin
        done = (cnt == LIMIT);
    end

    // Wait counter and sticky ready flag, both cleared between accesses.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt <= '0;
            ack <= 1'b0;
        end else begin
            if (!done) begin
                cnt <= cnt + CW'(1);
            end
            if (done && !busy) begin
                ack <= 1'b1;
            end
        end
    end

    AST_ACK_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(done && !busy && active)); // R6

    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && active) |=> (ack || !active)); // R5

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT); // R3

endmodule

// File: rtl/exp_ack_drive.sv
// Module: exp_ack_drive
// Forms the ready, override and acknowledge lines from the window hit,
// the selected mode and the timer's ready flag.
// Assumes 'hit' is already gated by reset and strobe.
module exp_ack_drive
    import exp_wait_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  ack_mode_e mode,
    input  logic      ready,
    output logic      xrdy,
    output logic      ovr_n,
    output logic      dtack_n
);

    // Combinational output lines; all idle as soon as hit drops.
    always_comb begin
        xrdy    = !(hit && (mode == MODE_STALL) && !ready);
        ovr_n   = !(hit && (mode == MODE_OVERRIDE));
        dtack_n = !(hit && (mode == MODE_OVERRIDE) && ready);
    end

    AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (xrdy && ovr_n && dtack_n)); // R7

    AST_DTACK_NEEDS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> !ovr_n); // R9

    AST_STALL_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STALL) |-> (ovr_n && dtack_n)); // R2

    AST_OVR_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OVERRIDE) |-> xrdy); // R4

endmodule

// File: rtl/exp_wait_ctrl.sv
// Module: exp_wait_ctrl (top)
// Wait-state controller for an expansion card on a 68000-style bus.
// Stalls the motherboard acknowledge through a ready line, or overrides it
// and acknowledges locally, for accesses to the card's own window only.
// Assumes mode_ovr is stable for the duration of an access.
module exp_wait_ctrl
    import exp_wait_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE = 24'hE80000,
    parameter logic [ADDR_W-1:0] WIN_MASK = 24'hFF0000,
    parameter int WAIT_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_n,
    input  logic              busy,
    input  logic              mode_ovr,
    output logic              xrdy,
    output logic              ovr_n,
    output logic              dtack_n,
    output logic              dev_sel
);

    logic      hit;
    logic      ready;
    ack_mode_e mode;

    // Map the raw mode pin onto the shared type.
    always_comb begin
        mode = ack_mode_e'(mode_ovr);
    end

    exp_addr_window #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_MASK (WIN_MASK)
    ) u_window (
        .en   (rst_n),
        .addr (addr),
        .as_n (as_n),
        .hit  (hit)
    );

    exp_wait_timer #(
        .WAIT_CLKS (WAIT_CLKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (hit),
        .busy   (busy),
        .ack    (ready)
    );

    exp_ack_drive u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .mode    (mode),
        .ready   (ready),
        .xrdy    (xrdy),
        .ovr_n   (ovr_n),
        .dtack_n (dtack_n)
    );

    // Local select follows the window hit directly.
    always_comb begin
        dev_sel = hit;
    end

    AST_IDLE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> (xrdy && ovr_n && dtack_n && !dev_sel)); // R8

endmodule

// File: tb/exp_wait_ctrl_tb.sv
`timescale 1ns/1ps
module exp_wait_ctrl_tb;

    localparam int CLK_PERIOD = 140;
    localparam int WAITS      = 2;
    localparam int MAX_EDGES  = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic        as_n = 1'b1;
    logic        busy = 1'b0;
    logic        mode_ovr = 1'b0;
    logic        xrdy, ovr_n, dtack_n, dev_sel;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exp_wait_ctrl #(
        .ADDR_W    (24),
        .WIN_BASE  (24'hE80000),
        .WIN_MASK  (24'hFF0000),
        .WAIT_CLKS (WAITS)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .as_n     (as_n),
        .busy     (busy),
        .mode_ovr (mode_ovr),
        .xrdy     (xrdy),
        .ovr_n    (ovr_n),
        .dtack_n  (dtack_n),
        .dev_sel  (dev_sel)
    );

    // mode, address, busy edges, expected ack edge (0 = never)
    typedef struct packed {
        logic        mode;
        logic [23:0] addr;
        logic [3:0]  busy_hold;
        logic [3:0]  exp_edge;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 24'hE80010, 4'd0, 4'd3},
        '{1'b0, 24'hE8FFFE, 4'd4, 4'd5},
        '{1'b1, 24'hE80100, 4'd0, 4'd3},
        '{1'b1, 24'hE84000, 4'd3, 4'd4},
        '{1'b0, 24'hC00000, 4'd0, 4'd0},
        '{1'b1, 24'hE90000, 4'd2, 4'd0},
        '{1'b1, 24'hE7FFFF, 4'd0, 4'd0},
        '{1'b0, 24'hE80000, 4'd2, 4'd3}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_access(input vec_t v);
        bit own;
        int seen;
        bit held;
        own  = (v.exp_edge != 0);
        seen = 0;
        held = 1'b1;
        @(negedge clk);
        mode_ovr = v.mode;
        addr     = v.addr;
        busy     = (v.busy_hold != 0);
        as_n     = 1'b0;
        #1;
        chk(dev_sel == own, "R1 dev_sel decode", dev_sel, own);
        if (!own) begin
            chk(xrdy && ovr_n && dtack_n, "R7 foreign access quiet",
                {xrdy, ovr_n, dtack_n}, 3'b111);
        end else if (!v.mode) begin
            chk(!xrdy && ovr_n, "R2 stall xrdy low at once", {xrdy, ovr_n}, 2'b01);
        end else begin
            chk(!ovr_n && xrdy, "R4 override ovr_n low at once", {xrdy, ovr_n}, 2'b10);
        end
        for (int e = 1; e <= MAX_EDGES; e++) begin
            @(negedge clk);
            if (dtack_n == 1'b0 && ovr_n == 1'b1) begin
                chk(1'b0, "R9 dtack without override", dtack_n, 1);
            end
            if (own && !v.mode && !ovr_n) begin
                chk(1'b0, "R2 override in stall mode", ovr_n, 1);
            end
            if (own && v.mode && !xrdy) begin
                chk(1'b0, "R4 xrdy stalled in override mode", xrdy, 1);
            end
            if (own) begin
                bit acked;
                acked = v.mode ? !dtack_n : xrdy;
                if (seen != 0 && !acked) held = 1'b0;
                if (seen == 0 && acked) seen = e;
            end else if (!xrdy || !ovr_n || !dtack_n) begin
                seen = e;
            end
            if (e == int'(v.busy_hold)) busy = 1'b0;
        end
        busy = 1'b0;
        if (v.busy_hold > WAITS) begin
            chk(seen == int'(v.exp_edge), "R6 busy delays ack", seen, v.exp_edge);
        end else if (!v.mode) begin
            chk(seen == int'(v.exp_edge), "R3 stall release edge", seen, v.exp_edge);
        end else begin
            chk(seen == int'(v.exp_edge), "R5 override ack edge", seen, v.exp_edge);
        end
        if (own) chk(held, "R5 ack held until strobe rises", held, 1);
        @(negedge clk);
        as_n = 1'b1;
        #1;
        chk(xrdy && ovr_n && dtack_n && !dev_sel, "R8 idle at strobe rise",
            {xrdy, ovr_n, dtack_n, dev_sel}, 4'b1110);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state with an own-window access present
        addr = 24'hE80020; as_n = 1'b0; mode_ovr = 1'b0;
        #1;
        chk(xrdy && ovr_n && dtack_n && !dev_sel, "R10 outputs idle in reset",
            {xrdy, ovr_n, dtack_n, dev_sel}, 4'b1110);
        mode_ovr = 1'b1;
        #1;
        chk(xrdy && ovr_n && dtack_n && !dev_sel, "R10 idle in reset override",
            {xrdy, ovr_n, dtack_n, dev_sel}, 4'b1110);
        @(negedge clk);
        as_n = 1'b1;
        rst_n = 1'b1;

        foreach (VECS[i]) run_access(VECS[i]);

        // back-to-back accesses restart the count (R8)
        run_access('{1'b1, 24'hE80200, 4'd0, 4'd3});

        // reset mid-access: count restarts after release (R10)
        begin
            int seen;
            seen = 0;
            @(negedge clk);
            mode_ovr = 1'b1; addr = 24'hE80300; busy = 1'b0; as_n = 1'b0;
            repeat (4) @(negedge clk);
            chk(!dtack_n, "R5 override ack before reset", dtack_n, 0);
            rst_n = 1'b0;
            #1;
            chk(dtack_n && ovr_n && xrdy && !dev_sel, "R10 reset forces idle",
                {xrdy, ovr_n, dtack_n, dev_sel}, 4'b1110);
            @(negedge clk);
            rst_n = 1'b1;
            for (int e = 1; e <= 6; e++) begin
                @(negedge clk);
                if (seen == 0 && !dtack_n) seen = e;
            end
            chk(seen == WAITS + 1, "R10 fresh count after reset", seen, WAITS + 1);
            @(negedge clk);
            as_n = 1'b1;
        end

        repeat (2) @(negedge clk);
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule